// File: doc/BRIEF.md
# Scanline Pixel Mask Generator

This block builds the pixel write-enable mask for a rasterizer, one horizontal line of a triangle or polygon at a time. Each line is a strip of 512 pixel positions. The mask goes out as sixteen beats of 32 bits over a valid/ready handshake. A pixel is enabled only when four tests all agree:
- the pixel lies inside the rectangular scissor window;
- the pixel lies inside the current line's left/right edge interval;
- the line lies inside the vertical range given for the shape;
- the stipple pattern bit for that pixel is set, or stippling is switched off.

A start pulse loads the initial edges and line number and emits the first line. After a line has been emitted, a next-line pulse adds the per-line edge increments, moves to the following line and emits it. Once the line number would pass the top of the vertical range, the block reports completion.

The control is a four-state machine:
- `ST_IDLE`: after reset. Start goes to `ST_EMIT`.
- `ST_EMIT`: beats 0..15 are sent. The last accepted beat goes to `ST_WAIT_LINE`.
- `ST_WAIT_LINE`: start goes to `ST_EMIT` with a reload. Next-line goes to `ST_EMIT` with a step, or to `ST_DONE` when the stepped line would exceed the range.
- `ST_DONE`: start goes to `ST_EMIT` with a reload.

Top module: `span_mask_gen`

## Requirements
- R1: After reset, `mask_valid` and `done` are 0.
- R2: A `start` pulse in idle, wait or done state loads the edges and `y_init`, then presents beats with `mask_seg` = 0,1,...,15 in order. Beat k covers pixels x = 32k..32k+31, with pixel x at bit (x mod 32) of `mask_bits`. Each beat holds unchanged while `mask_ready` is 0.
- R3: Edges are signed fixed point with 16 integer and 16 fraction bits. Pixel x is covered when ceil(left) <= x < ceil(right). An empty or inverted interval gives no pixels.
- R4: Pixels with x outside [`win_x_min`, `win_x_max`] are masked off, inclusive on both ends. A line with y outside [`win_y_min`, `win_y_max`] is masked off entirely.
- R5: A line with y outside [`span_y_min`, `span_y_max`] produces an all-zero mask.
- R6: When `stip_en` is 1, pixel x on line y also requires bit (x mod 32) of stipple row (y mod 32). Row r is written by `stip_we` with `stip_addr`=r and `stip_wdata`. When `stip_en` is 0, the pattern has no effect.
- R7: A `next_line` pulse in wait state adds `edge_l_delta` and `edge_r_delta` to the edges, increments y and emits the new line. `next_line` during emission is ignored.
- R8: When `next_line` arrives and y+1 > `span_y_max`, the block enters done state (`done`=1, `mask_valid`=0). It stays there, ignoring `next_line`, until `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_x_min | input | 16 | Scissor left bound (inclusive) |
| win_x_max | input | 16 | Scissor right bound (inclusive) |
| win_y_min | input | 16 | Scissor lower line bound (inclusive) |
| win_y_max | input | 16 | Scissor upper line bound (inclusive) |
| span_y_min | input | 16 | First line of the shape |
| span_y_max | input | 16 | Last line of the shape |
| y_init | input | 16 | Line loaded by start |
| edge_l_init | input | 32 | Initial left edge, 16.16 signed |
| edge_r_init | input | 32 | Initial right edge, 16.16 signed |
| edge_l_delta | input | 32 | Left edge increment per line, 16.16 signed |
| edge_r_delta | input | 32 | Right edge increment per line, 16.16 signed |
| stip_en | input | 1 | Apply stipple pattern |
| stip_we | input | 1 | Stipple row write strobe |
| stip_addr | input | 5 | Stipple row to write |
| stip_wdata | input | 32 | Stipple row contents |
| start | input | 1 | Load and emit first line |
| next_line | input | 1 | Step to and emit next line |
| mask_ready | input | 1 | Consumer accepts current beat |
| mask_valid | output | 1 | Beat present |
| mask_seg | output | 4 | Segment index of beat |
| mask_y | output | 16 | Line number of beat |
| mask_bits | output | 32 | Pixel enables of beat |
| done | output | 1 | Vertical range exhausted |

## Verification
A table of edge pairs is run through the mask path with the window fully open and stippling off. The pairs are:
- whole-pixel edges;
- fractional edges, which separate correct ceiling rounding from truncation;
- a negative left edge, which shows correct handling of the sign;
- equal and inverted edges, which must give an empty mask;
- an interval crossing a segment boundary, and one running past the last segment, which check the segment base.

Directed runs then narrow the window to catch off-by-one bound errors. They also:
- move the line below the vertical range;
- load two different stipple rows, to show the row is picked by line and the bit by column;
- step the edges with fractional increments over several lines, which shows the accumulation and the y increment;
- hold the ready input low, which shows whether a beat can be skipped.

// File: rtl/span_mask_pkg.sv
package span_mask_pkg;

    localparam int FX_W    = 32;
    localparam int FX_FRAC = 16;
    localparam int FX_INT  = FX_W - FX_FRAC;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_EMIT      = 2'd1,
        ST_WAIT_LINE = 2'd2,
        ST_DONE      = 2'd3
    } span_state_e;

    // Smallest integer not below a signed fixed-point value.
    function automatic logic signed [FX_INT:0] fx_ceil(input logic signed [FX_W-1:0] v);
        logic signed [FX_W:0] s;
        s = $signed({v[FX_W-1], v}) + $signed({{(FX_INT+1){1'b0}}, {FX_FRAC{1'b1}}});
        return s[FX_W:FX_FRAC];
    endfunction

endpackage

// File: rtl/span_edge_stepper.sv
module span_edge_stepper
    import span_mask_pkg::*;
#(
    parameter int COORD_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     step,
    input  logic signed [FX_W-1:0]   l_init,
    input  logic signed [FX_W-1:0]   r_init,
    input  logic [COORD_W-1:0]       y_init,
    input  logic signed [FX_W-1:0]   l_delta,
    input  logic signed [FX_W-1:0]   r_delta,
    output logic signed [FX_W-1:0]   cur_l,
    output logic signed [FX_W-1:0]   cur_r,
    output logic [COORD_W-1:0]       cur_y
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_l <= '0;
            cur_r <= '0;
            cur_y <= '0;
        end else if (load) begin
            cur_l <= l_init;
            cur_r <= r_init;
            cur_y <= y_init;
        end else if (step) begin
            cur_l <= cur_l + l_delta;
            cur_r <= cur_r + r_delta;
            cur_y <= cur_y + COORD_W'(1);
        end
    end

    AST_Y_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> cur_y == $past(cur_y) + COORD_W'(1)); // R7

    AST_LOAD_TAKES_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur_y == $past(y_init)); // R2

endmodule

// File: rtl/span_stipple_store.sv
module span_stipple_store #(
    parameter int STIP_N = 32,
    localparam int STIP_BITS = $clog2(STIP_N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [STIP_BITS-1:0] waddr,
    input  logic [STIP_N-1:0]    wdata,
    input  logic [STIP_BITS-1:0] raddr,
    output logic [STIP_N-1:0]    rdata
);

    logic [STIP_N-1:0] rows [STIP_N];

    generate
        for (genvar r = 0; r < STIP_N; r++) begin : g_row
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rows[r] <= '0;
                end else if (we && waddr == STIP_BITS'(r)) begin
                    rows[r] <= wdata;
                end
            end
        end
    endgenerate

    assign rdata = rows[raddr];

endmodule

// File: rtl/span_seg_mask.sv
module span_seg_mask
    import span_mask_pkg::*;
#(
    parameter int SEG_W   = 32,
    parameter int NUM_SEG = 16,
    parameter int COORD_W = 16,
    parameter int STIP_N  = 32,
    localparam int SEG_BITS  = $clog2(SEG_W),
    localparam int SEG_IDX_W = $clog2(NUM_SEG),
    localparam int XW        = SEG_IDX_W + SEG_BITS,
    localparam int STIP_BITS = $clog2(STIP_N),
    localparam int CMP_W     = COORD_W + 2
) (
    input  logic [SEG_IDX_W-1:0]     seg,
    input  logic signed [FX_W-1:0]   cur_l,
    input  logic signed [FX_W-1:0]   cur_r,
    input  logic [COORD_W-1:0]       cur_y,
    input  logic [COORD_W-1:0]       win_x_min,
    input  logic [COORD_W-1:0]       win_x_max,
    input  logic [COORD_W-1:0]       win_y_min,
    input  logic [COORD_W-1:0]       win_y_max,
    input  logic [COORD_W-1:0]       span_y_min,
    input  logic [COORD_W-1:0]       span_y_max,
    input  logic                     stip_en,
    input  logic [STIP_N-1:0]        stip_row,
    output logic [SEG_W-1:0]         mask
);

    logic signed [FX_INT:0]  l_ceil, r_ceil;
    logic signed [CMP_W-1:0] l_cmp, r_cmp;
    logic                    row_ok;

    assign l_ceil = fx_ceil(cur_l);
    assign r_ceil = fx_ceil(cur_r);
    assign l_cmp  = CMP_W'(l_ceil);
    assign r_cmp  = CMP_W'(r_ceil);

    assign row_ok = (cur_y >= win_y_min) && (cur_y <= win_y_max) &&
                    (cur_y >= span_y_min) && (cur_y <= span_y_max);

    generate
        for (genvar i = 0; i < SEG_W; i++) begin : g_pix
            localparam logic [SEG_BITS-1:0] LO = SEG_BITS'(i);
            logic [XW-1:0]           px;
            logic [COORD_W-1:0]      px_c;
            logic signed [CMP_W-1:0] px_s;
            logic                    in_win, in_span, stip_ok;

            assign px      = {seg, LO};
            assign px_c    = COORD_W'(px);
            assign px_s    = $signed({2'b00, px_c});
            assign in_win  = (px_c >= win_x_min) && (px_c <= win_x_max);
            assign in_span = (px_s >= l_cmp) && (px_s < r_cmp);
            assign stip_ok = !stip_en || stip_row[px[STIP_BITS-1:0]];
            assign mask[i] = row_ok && in_win && in_span && stip_ok;
        end
    endgenerate

endmodule

// File: rtl/span_mask_gen.sv
module span_mask_gen
    import span_mask_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] win_x_min,
    input  logic [15:0] win_x_max,
    input  logic [15:0] win_y_min,
    input  logic [15:0] win_y_max,
    input  logic [15:0] span_y_min,
    input  logic [15:0] span_y_max,
    input  logic [15:0] y_init,
    input  logic [31:0] edge_l_init,
    input  logic [31:0] edge_r_init,
    input  logic [31:0] edge_l_delta,
    input  logic [31:0] edge_r_delta,
    input  logic        stip_en,
    input  logic        stip_we,
    input  logic [4:0]  stip_addr,
    input  logic [31:0] stip_wdata,
    input  logic        start,
    input  logic        next_line,
    input  logic        mask_ready,
    output logic        mask_valid,
    output logic [3:0]  mask_seg,
    output logic [15:0] mask_y,
    output logic [31:0] mask_bits,
    output logic        done
);

    localparam int SEG_W     = 32;
    localparam int NUM_SEG   = 16;
    localparam int COORD_W   = 16;
    localparam int STIP_N    = 32;
    localparam int SEG_IDX_W = $clog2(NUM_SEG);
    localparam int STIP_BITS = $clog2(STIP_N);
    localparam logic [SEG_IDX_W-1:0] LAST_SEG = SEG_IDX_W'(NUM_SEG - 1);

    span_state_e            state, state_nxt;
    logic [SEG_IDX_W-1:0]   seg, seg_nxt;
    logic                   do_load, do_step, y_over;
    logic signed [FX_W-1:0] cur_l, cur_r;
    logic [COORD_W-1:0]     cur_y;
    logic [STIP_N-1:0]      stip_row;

    assign y_over = ({1'b0, cur_y} + (COORD_W+1)'(1)) > {1'b0, span_y_max};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            seg   <= '0;
        end else begin
            state <= state_nxt;
            seg   <= seg_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        seg_nxt   = seg;
        do_load   = 1'b0;
        do_step   = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_nxt = ST_EMIT;
                    seg_nxt   = '0;
                    do_load   = 1'b1;
                end
            end
            ST_EMIT: begin
                if (mask_ready) begin
                    if (seg == LAST_SEG) begin
                        state_nxt = ST_WAIT_LINE;
                        seg_nxt   = '0;
                    end else begin
                        seg_nxt = seg + SEG_IDX_W'(1);
                    end
                end
            end
            ST_WAIT_LINE: begin
                if (start) begin
                    state_nxt = ST_EMIT;
                    seg_nxt   = '0;
                    do_load   = 1'b1;
                end else if (next_line) begin
                    if (y_over) begin
                        state_nxt = ST_DONE;
                    end else begin
                        state_nxt = ST_EMIT;
                        seg_nxt   = '0;
                        do_step   = 1'b1;
                    end
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mask_valid = (state == ST_EMIT);
        done       = (state == ST_DONE);
        mask_seg   = seg;
        mask_y     = cur_y;
    end

    span_edge_stepper #(.COORD_W(COORD_W)) u_stepper (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (do_load),
        .step    (do_step),
        .l_init  ($signed(edge_l_init)),
        .r_init  ($signed(edge_r_init)),
        .y_init  (y_init),
        .l_delta ($signed(edge_l_delta)),
        .r_delta ($signed(edge_r_delta)),
        .cur_l   (cur_l),
        .cur_r   (cur_r),
        .cur_y   (cur_y)
    );

    span_stipple_store #(.STIP_N(STIP_N)) u_stipple (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (stip_we),
        .waddr (stip_addr),
        .wdata (stip_wdata),
        .raddr (cur_y[STIP_BITS-1:0]),
        .rdata (stip_row)
    );

    span_seg_mask #(
        .SEG_W   (SEG_W),
        .NUM_SEG (NUM_SEG),
        .COORD_W (COORD_W),
        .STIP_N  (STIP_N)
    ) u_mask (
        .seg        (seg),
        .cur_l      (cur_l),
        .cur_r      (cur_r),
        .cur_y      (cur_y),
        .win_x_min  (win_x_min),
        .win_x_max  (win_x_max),
        .win_y_min  (win_y_min),
        .win_y_max  (win_y_max),
        .span_y_min (span_y_min),
        .span_y_max (span_y_max),
        .stip_en    (stip_en),
        .stip_row   (stip_row),
        .mask       (mask_bits)
    );

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_valid && !mask_ready) |=> (mask_valid && $stable(mask_seg))); // R2

    AST_SEG_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_valid && mask_ready && mask_seg != LAST_SEG) |=>
        (mask_valid && mask_seg == $past(mask_seg) + SEG_IDX_W'(1))); // R2

    AST_ZERO_OUTSIDE_YRANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_valid && (mask_y < span_y_min || mask_y > span_y_max)) |-> mask_bits == '0); // R5

    AST_LINE_FIXED_DURING_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        mask_valid |=> $stable(mask_y)); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && !mask_valid)); // R8

endmodule

// File: tb/span_mask_gen_tb.sv
module span_mask_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] win_x_min, win_x_max, win_y_min, win_y_max;
    logic [15:0] span_y_min, span_y_max, y_init;
    logic [31:0] edge_l_init, edge_r_init, edge_l_delta, edge_r_delta;
    logic        stip_en, stip_we;
    logic [4:0]  stip_addr;
    logic [31:0] stip_wdata;
    logic        start, next_line, mask_ready;
    logic        mask_valid, done;
    logic [3:0]  mask_seg;
    logic [15:0] mask_y;
    logic [31:0] mask_bits;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    span_mask_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .win_x_min(win_x_min), .win_x_max(win_x_max),
        .win_y_min(win_y_min), .win_y_max(win_y_max),
        .span_y_min(span_y_min), .span_y_max(span_y_max), .y_init(y_init),
        .edge_l_init(edge_l_init), .edge_r_init(edge_r_init),
        .edge_l_delta(edge_l_delta), .edge_r_delta(edge_r_delta),
        .stip_en(stip_en), .stip_we(stip_we), .stip_addr(stip_addr), .stip_wdata(stip_wdata),
        .start(start), .next_line(next_line), .mask_ready(mask_ready),
        .mask_valid(mask_valid), .mask_seg(mask_seg), .mask_y(mask_y),
        .mask_bits(mask_bits), .done(done)
    );

    // {left edge, right edge, segment, expected mask}
    localparam logic [127:0] VEC [7] = '{
        {32'h0003_0000, 32'h000A_0000, 32'd0,  32'h0000_03F8},
        {32'h0002_8000, 32'h0005_4000, 32'd0,  32'h0000_0038},
        {32'h001E_0000, 32'h0028_0000, 32'd1,  32'h0000_00FF},
        {32'hFFFA_8000, 32'h0002_0000, 32'd0,  32'h0000_0003},
        {32'h0007_0000, 32'h0007_0000, 32'd0,  32'h0000_0000},
        {32'h0064_0000, 32'h0258_0000, 32'd15, 32'hFFFF_FFFF},
        {32'h0005_0000, 32'h0003_0000, 32'd0,  32'h0000_0000}
    };

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    task automatic do_start;
        start = 1'b1;
        tick;
        start = 1'b0;
    endtask

    task automatic do_next;
        next_line = 1'b1;
        tick;
        next_line = 1'b0;
    endtask

    task automatic grab_line(input int want, output logic [31:0] m);
        m = 32'hDEAD_BEEF;
        mask_ready = 1'b1;
        for (int k = 0; k < 16; k++) begin
            if (mask_valid && mask_seg == 4'(want)) m = mask_bits;
            tick;
        end
    endtask

    task automatic set_edges(input logic [31:0] l, input logic [31:0] r);
        edge_l_init = l;
        edge_r_init = r;
    endtask

    task automatic write_row(input logic [4:0] a, input logic [31:0] d);
        stip_we = 1'b1; stip_addr = a; stip_wdata = d;
        tick;
        stip_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary;
    end

    initial begin
        logic [31:0] m;
        win_x_min = 16'd0; win_x_max = 16'd511; win_y_min = 16'd0; win_y_max = 16'd1023;
        span_y_min = 16'd0; span_y_max = 16'd100; y_init = 16'd5;
        edge_l_init = '0; edge_r_init = '0; edge_l_delta = '0; edge_r_delta = '0;
        stip_en = 1'b0; stip_we = 1'b0; stip_addr = '0; stip_wdata = '0;
        start = 1'b0; next_line = 1'b0; mask_ready = 1'b0;
        repeat (3) tick;
        rst_n = 1'b1;
        tick;

        // R1 reset state
        check("R1", "valid after reset", 32'(mask_valid), 32'd0);
        check("R1", "done after reset", 32'(done), 32'd0);

        // R3 table of edge pairs
        foreach (VEC[n]) begin
            set_edges(VEC[n][127:96], VEC[n][95:64]);
            do_start;
            grab_line(int'(VEC[n][63:32]), m);
            check("R3", $sformatf("vector %0d", n), m, VEC[n][31:0]);
        end

        // R2 handshake hold and ordering
        set_edges(32'h0000_0000, 32'h0020_0000);
        mask_ready = 1'b0;
        do_start;
        check("R2", "line loaded", 32'(mask_y), 32'd5);
        repeat (3) tick;
        check("R2", "valid held", 32'(mask_valid), 32'd1);
        check("R2", "seg held", 32'(mask_seg), 32'd0);
        // R7 next_line ignored while emitting
        do_next;
        check("R7", "y unchanged during emit", 32'(mask_y), 32'd5);
        check("R7", "seg unchanged during emit", 32'(mask_seg), 32'd0);
        mask_ready = 1'b1;
        tick;
        check("R2", "seg advanced", 32'(mask_seg), 32'd1);
        repeat (15) tick;
        check("R2", "line ends after 16 beats", 32'(mask_valid), 32'd0);

        // R4 window scissor
        win_x_min = 16'd8; win_x_max = 16'd15;
        do_start; grab_line(0, m);
        check("R4", "x window 8..15", m, 32'h0000_FF00);
        win_x_min = 16'd0; win_x_max = 16'd511;
        win_y_min = 16'd10; win_y_max = 16'd20;
        do_start; grab_line(0, m);
        check("R4", "line outside y window", m, 32'h0);
        win_y_min = 16'd0; win_y_max = 16'd1023;

        // R5 vertical span range
        span_y_min = 16'd6;
        do_start; grab_line(0, m);
        check("R5", "line below span range", m, 32'h0);
        do_next; grab_line(0, m);
        check("R5", "first line in range", m, 32'hFFFF_FFFF);
        span_y_min = 16'd0;

        // R6 stipple
        write_row(5'd5, 32'hA5A5_A5A5);
        write_row(5'd6, 32'h0F0F_0F0F);
        stip_en = 1'b1;
        set_edges(32'h0000_0000, 32'h0040_0000);
        do_start; grab_line(0, m);
        check("R6", "row 5 pattern seg 0", m, 32'hA5A5_A5A5);
        do_start; grab_line(1, m);
        check("R6", "row 5 pattern seg 1", m, 32'hA5A5_A5A5);
        do_next; grab_line(0, m);
        check("R6", "row 6 pattern", m, 32'h0F0F_0F0F);
        stip_en = 1'b0;
        do_start; grab_line(0, m);
        check("R6", "stipple bypassed", m, 32'hFFFF_FFFF);

        // R7 edge stepping
        set_edges(32'h0003_0000, 32'h000A_0000);
        edge_l_delta = 32'h0001_8000; edge_r_delta = 32'h0000_8000;
        do_start; grab_line(0, m);
        check("R7", "line 0 of stepping", m, 32'h0000_03F8);
        do_next;
        check("R7", "y incremented", 32'(mask_y), 32'd6);
        grab_line(0, m);
        check("R7", "after one step", m, 32'h0000_07E0);
        do_next; grab_line(0, m);
        check("R7", "after two steps", m, 32'h0000_07C0);
        edge_l_delta = '0; edge_r_delta = '0;

        // R8 done
        span_y_max = 16'd6;
        do_start; grab_line(0, m);
        do_next;
        check("R8", "last line still emitted", 32'(mask_valid), 32'd1);
        grab_line(0, m);
        do_next;
        check("R8", "done raised", 32'(done), 32'd1);
        check("R8", "no beat when done", 32'(mask_valid), 32'd0);
        do_next; tick;
        check("R8", "done stays on next_line", 32'(done), 32'd1);
        do_start;
        check("R8", "start clears done", 32'(done), 32'd0);
        check("R8", "start resumes beats", 32'(mask_valid), 32'd1);

        summary;
    end

endmodule